// File: doc/BRIEF.md
# Buffered SPI Transfer Engine

This block is the SPI side of a bus bridge. A host front-end fills a shared byte buffer and then issues a start strobe with a byte count and a slave-select mask. The engine then runs one full-duplex SPI transfer over buffer entries 0 to count-1. Each outgoing byte is fetched from the buffer, and the byte received on MISO during that same byte time is written back to the same entry. When the transfer ends, the buffer holds the slave's reply in place of the data that was sent.

A packed configuration byte sets the clock idle level, the sampling edge, the bit order and one of four clock rates. All four rates are derived from the reference clock. Completion raises a sticky active-low interrupt, which stays low until an explicit clear. A host that prefers to poll may watch the busy flag and never clear the interrupt. Select lines handed over to general-purpose use are left deasserted by the engine.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, busy_o is 0, irq_no is 1, ss_no is all ones, sclk_o is 0 and mosi_o is 0. The configuration is MSB first, mode 00 and rate 00.
- R2: A start with count N, where 1 <= N <= BUF_DEPTH, shifts out buffer entries 0..N-1 in address order, exactly 8*N sampling edges. Each received byte is written over the entry it replaced. A start with N = 0 or N > BUF_DEPTH is ignored.
- R3: Mask bit i drives ss_no[i] low from the start until the release, for any combination of bits. A line whose gpio_en_i bit is 1 stays high throughout.
- R4: Configuration bit 5 selects the bit order: 0 sends and receives MSB first, 1 sends and receives LSB first.
- R5: Configuration bits 3:2 select the mode. 00 idles low and samples on the leading edge. 01 idles low and samples on the trailing edge. 10 idles high and samples on the trailing edge. 11 idles high and samples on the leading edge. MOSI changes only on the non-sampling edges.
- R6: Configuration bits 1:0 select the SCK half-period as DIV_BASE times 1, 4, 16 or 32 reference cycles, for codes 00, 01, 10 and 11.
- R7: irq_no falls when a transfer completes. It stays low, across further transfers, until irq_clr_i is pulsed, and it is 1 in the cycle after that pulse.
- R8: While busy_o is 1, start_i and configuration writes are ignored.
- R9: The selects release and busy_o falls one half-period plus one reference cycle after the last SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 8 | Packed configuration byte |
| start_i | input | 1 | Transfer start strobe |
| start_cnt_i | input | CNT_W | Number of bytes to transfer |
| start_mask_i | input | NUM_SS | Select lines to assert |
| gpio_en_i | input | NUM_SS | Lines owned by general-purpose use |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| busy_o | output | 1 | Transfer in progress |
| irq_no | output | 1 | Completion interrupt, active low |
| buf_rd_o | output | 1 | Buffer read request, data expected next cycle |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | ADDR_W | Buffer address |
| buf_wdata_o | output | 8 | Received byte for write-back |
| buf_rdata_i | input | 8 | Buffer read data |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| ss_no | output | NUM_SS | Slave selects, active low |

## Verification
All four modes are run in both bit orders against a slave model that changes MISO only after each sampling edge. If the engine samples or shifts on the wrong edge, both the captured MOSI bytes and the written-back buffer come out wrong. Random byte counts, masks, rates and general-purpose ownership are mixed in. Lengths of one byte and of the full buffer test the address bounds. Counts of zero and one past the depth, and start and configuration pokes during a transfer, show whether the ignore rules hold. The first edge spacing and the tail delay separate the four rates.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef struct packed {
    logic       lsb_first;
    logic [1:0] mode;
    logic [1:0] rate;
  } spi_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_LOAD, ST_SHIFT, ST_WRITE, ST_TAIL
  } eng_state_t;

  function automatic spi_cfg_t unpack_cfg(input logic [7:0] b);
    spi_cfg_t c;
    c.lsb_first = b[5];
    c.mode      = b[3:2];
    c.rate      = b[1:0];
    return c;
  endfunction

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int DIV_BASE = 2,
  localparam int MAX_HALF = DIV_BASE * 32,
  localparam int CW = $clog2(MAX_HALF + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       tick_o
);

  logic [CW-1:0] cnt_q, half_m1;

  always_comb begin
    case (rate_i)
      2'd0:    half_m1 = CW'(DIV_BASE - 1);
      2'd1:    half_m1 = CW'(DIV_BASE * 4 - 1);
      2'd2:    half_m1 = CW'(DIV_BASE * 16 - 1);
      default: half_m1 = CW'(DIV_BASE * 32 - 1);
    endcase
  end

  assign tick_o = en_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= half_m1); // R6

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       tick_i,
  input  logic       lsb_first_i,
  input  logic       samp_trail_i,
  input  logic       miso_i,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       phase_o,
  output logic       last_o
);

  logic [7:0] tx_q, rx_q;
  logic [3:0] edge_q;
  logic       phase_q;
  logic       lead, smp;

  assign lead    = ~edge_q[0];
  assign smp     = lead ^ samp_trail_i;
  assign last_o  = tick_i && (edge_q == 4'd15);
  assign mosi_o  = lsb_first_i ? tx_q[0] : tx_q[7];
  assign rx_o    = rx_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0; rx_q <= '0; edge_q <= '0; phase_q <= 1'b0;
    end else if (load_i) begin
      tx_q <= data_i; edge_q <= '0; phase_q <= 1'b0;
    end else if (tick_i) begin
      edge_q  <= edge_q + 1'b1;
      phase_q <= ~phase_q;
      if (smp)
        rx_q <= lsb_first_i ? {miso_i, rx_q[7:1]} : {rx_q[6:0], miso_i};
      else if (edge_q != 4'd0)  // first edge of a byte keeps bit 0 on the line
        tx_q <= lsb_first_i ? {1'b0, tx_q[7:1]} : {tx_q[6:0], 1'b0};
    end
  end

  AST_IDLE_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !phase_q); // R5

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine import spi_eng_pkg::*; #(
  parameter int BUF_DEPTH = 200,
  parameter int DIV_BASE  = 2,
  parameter int NUM_SS    = 4,
  localparam int ADDR_W = $clog2(BUF_DEPTH),
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_data_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic [NUM_SS-1:0] start_mask_i,
  input  logic [NUM_SS-1:0] gpio_en_i,
  input  logic              irq_clr_i,
  output logic              busy_o,
  output logic              irq_no,
  output logic              buf_rd_o,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no
);

  eng_state_t          state_q;
  spi_cfg_t            cfg_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [NUM_SS-1:0]   mask_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                irq_q;
  logic                tick, byte_end, phase, sh_mosi, start_ok, last_byte, done;
  logic [7:0]          rx_byte;

  assign start_ok  = start_i && (start_cnt_i != '0) && (start_cnt_i <= CNT_W'(BUF_DEPTH));
  assign last_byte = (CNT_W'(addr_q) + CNT_W'(1)) == cnt_q;
  assign done      = (state_q == ST_TAIL) && tick;

  spi_rate_div #(.DIV_BASE(DIV_BASE)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (cfg_q.rate),
    .en_i   ((state_q == ST_SHIFT) || (state_q == ST_TAIL)),
    .clr_i  ((state_q == ST_LOAD) || (state_q == ST_WRITE)),
    .tick_o (tick)
  );

  spi_byte_shifter u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (state_q == ST_LOAD),
    .data_i       (buf_rdata_i),
    .tick_i       (tick && (state_q == ST_SHIFT)),
    .lsb_first_i  (cfg_q.lsb_first),
    .samp_trail_i (cfg_q.mode[1] ^ cfg_q.mode[0]),
    .miso_i       (miso_i),
    .mosi_o       (sh_mosi),
    .rx_o         (rx_byte),
    .phase_o      (phase),
    .last_o       (byte_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      addr_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (cfg_we_i && state_q == ST_IDLE) cfg_q <= unpack_cfg(cfg_data_i);
      if (done)           irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_ok) begin
          cnt_q   <= start_cnt_i;
          mask_q  <= start_mask_i;
          addr_q  <= '0;
          state_q <= ST_READ;
        end
        ST_READ:  state_q <= ST_LOAD;
        ST_LOAD:  state_q <= ST_SHIFT;
        ST_SHIFT: if (byte_end) state_q <= ST_WRITE;
        ST_WRITE: if (last_byte) state_q <= ST_TAIL;
                  else begin
                    addr_q  <= addr_q + 1'b1;
                    state_q <= ST_READ;
                  end
        ST_TAIL:  if (tick) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign irq_no      = ~irq_q;
  assign buf_rd_o    = (state_q == ST_READ);
  assign buf_we_o    = (state_q == ST_WRITE);
  assign buf_addr_o  = addr_q;
  assign buf_wdata_o = rx_byte;
  assign sclk_o      = cfg_q.mode[1] ^ phase;
  assign mosi_o      = busy_o ? sh_mosi : 1'b0;

  for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
    assign ss_no[i] = !(busy_o && mask_q[i] && !gpio_en_i[i]);
  end

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(cfg_q)); // R8
  AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mask_q)); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no && !irq_clr_i |=> !irq_no); // R7
  AST_DONE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !irq_no); // R7
  AST_WR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> CNT_W'(buf_addr_o) < cnt_q); // R2

endmodule

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;
  localparam int DEPTH = 200;
  localparam int DIVB  = 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, start = 0, irq_clr = 0, miso = 0;
  logic [7:0] cfg_data = 0;
  logic [CW-1:0] start_cnt = 0;
  logic [3:0] start_mask = 0, gpio_en = 0;
  logic busy, irq_n, buf_rd, buf_we, sclk, mosi;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata, buf_rdata;
  logic [3:0] ss_n;

  always #10 clk = ~clk;

  spi_xfer_engine #(.BUF_DEPTH(DEPTH), .DIV_BASE(DIVB), .NUM_SS(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
    .start_i(start), .start_cnt_i(start_cnt), .start_mask_i(start_mask),
    .gpio_en_i(gpio_en), .irq_clr_i(irq_clr), .busy_o(busy), .irq_no(irq_n),
    .buf_rd_o(buf_rd), .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .ss_no(ss_n));

  logic [7:0] mem [DEPTH];
  always @(posedge clk) begin
    if (buf_rd) buf_rdata <= mem[buf_addr];
    if (buf_we) mem[buf_addr] <= buf_wdata;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  // slave model and observer
  logic [7:0] orig [DEPTH];
  logic [7:0] slv  [DEPTH];
  logic [7:0] mo   [DEPTH];
  bit   mon_on = 0, cur_lsb = 0, cur_cpol = 0, cur_trail = 0, prev_sclk = 0, prev_busy = 0;
  int   cur_n = 0, samp = 0, edges = 0, cyc = 0, last_edge = 0, spacing = 0, tail = 0, ss_err = 0;
  logic [3:0] exp_ss = 4'hF, ss_end = 4'h0;

  function automatic logic sbit(input int idx);
    logic [7:0] b;
    if (idx >= 8 * cur_n) return 1'b0;
    b = slv[idx / 8];
    return cur_lsb ? b[idx % 8] : b[7 - idx % 8];
  endfunction

  function automatic int half_of(input logic [1:0] r);
    case (r)
      2'd0: return DIVB;
      2'd1: return DIVB * 4;
      2'd2: return DIVB * 16;
      default: return DIVB * 32;
    endcase
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (sclk !== prev_sclk) begin
        edges++;
        if (edges == 2) spacing = cyc - last_edge;
        last_edge = cyc;
        if ((sclk != cur_cpol) ^ cur_trail) begin
          if (samp < 8 * cur_n) begin
            if (cur_lsb) mo[samp / 8][samp % 8] = mosi;
            else         mo[samp / 8][7 - samp % 8] = mosi;
          end
          if (ss_n !== exp_ss) ss_err++;
          samp++;
        end
      end
      if (prev_busy && !busy) begin
        tail  = cyc - last_edge;
        ss_end = ss_n;
      end
      prev_sclk = sclk;
      prev_busy = busy;
      miso = sbit(samp);
    end
  end

  task automatic do_xfer(input int n, input logic [3:0] mask, input logic [7:0] cfg,
                         input logic [3:0] gpio, input bit write_cfg, input bit poke,
                         input bit clear_after);
    int half, bad, first_bad;
    if (write_cfg) begin
      @(negedge clk); cfg_we = 1; cfg_data = cfg;
      @(negedge clk); cfg_we = 0;
    end
    gpio_en = gpio;
    for (int i = 0; i < n; i++) begin
      orig[i] = 8'($urandom); slv[i] = 8'($urandom); mem[i] = orig[i]; mo[i] = 8'h00;
    end
    cur_n = n; cur_lsb = cfg[5]; cur_cpol = cfg[3]; cur_trail = cfg[3] ^ cfg[2];
    half = half_of(cfg[1:0]);
    exp_ss = ~(mask & ~gpio);
    samp = 0; edges = 0; cyc = 0; last_edge = 0; spacing = 0; tail = -1; ss_err = 0;
    @(negedge clk);
    chk(sclk == cur_cpol, "R5 idle level", sclk, cur_cpol);
    prev_sclk = sclk; prev_busy = 0; mon_on = 1;
    @(negedge clk); start = 1; start_cnt = CW'(n); start_mask = mask;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; start_cnt = CW'(1); start_mask = 4'hF;
      cfg_we = 1; cfg_data = cfg ^ 8'h28;
      @(negedge clk); start = 0; cfg_we = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    mon_on = 0;
    bad = 0; first_bad = -1;
    for (int i = 0; i < n; i++)
      if (mo[i] !== orig[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (first_bad < 0) first_bad = 0;
    chk(bad == 0, "R2/R4/R5 mosi bytes", mo[first_bad], orig[first_bad]);
    bad = 0; first_bad = -1;
    for (int i = 0; i < n; i++)
      if (mem[i] !== slv[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (first_bad < 0) first_bad = 0;
    chk(bad == 0, "R2/R4/R5 in-place write-back", mem[first_bad], slv[first_bad]);
    chk(samp == 8 * n, "R2 sample edge count", samp, 8 * n);
    chk(ss_err == 0, "R3 select lines during transfer", ss_err, 0);
    chk(ss_end == 4'hF, "R9 selects released", ss_end, 4'hF);
    if (n > 0) chk(spacing == half, "R6 half-period", spacing, half);
    chk(tail == half + 1, "R9 tail delay", tail, half + 1);
    chk(irq_n == 1'b0, "R7 irq after completion", irq_n, 0);
    if (poke) begin
      chk(sclk == cur_cpol, "R8 config write ignored while busy", sclk, cur_cpol);
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R8 start ignored while busy", busy, 0);
    end
    if (clear_after) begin
      irq_clr = 1; @(negedge clk); irq_clr = 0;
      chk(irq_n == 1'b1, "R7 irq cleared", irq_n, 1);
    end
  endtask

  task automatic bad_start(input int n);
    @(negedge clk); start = 1; start_cnt = CW'(n); start_mask = 4'hF;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && ss_n == 4'hF, "R2 out-of-range count ignored", {busy, ss_n}, 5'h0F);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy at reset", busy, 0);
    chk(irq_n == 1, "R1 irq at reset", irq_n, 1);
    chk(ss_n == 4'hF, "R1 selects at reset", ss_n, 4'hF);
    chk(sclk == 0 && mosi == 0, "R1 sclk/mosi at reset", {sclk, mosi}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 default configuration: MSB first, mode 00, fastest
    do_xfer(3, 4'b0001, 8'h00, 4'h0, 0, 0, 1);
    // R4 R5: every mode in both orders
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        do_xfer(2 + m, 4'b0100, {2'b00, 1'(o), 1'b0, 2'(m), 2'(m % 3)}, 4'h0, 1, 0, 1);
    // R6 each rate
    for (int r = 0; r < 4; r++)
      do_xfer(1, 4'b1000, {6'b000001, 2'(r)}, 4'h0, 1, 0, 1);
    // R2 boundary counts
    bad_start(0);
    bad_start(DEPTH + 1);
    do_xfer(DEPTH, 4'b0010, 8'h20, 4'h0, 1, 0, 1);
    // R3 multiple selects, GPIO-owned lines held high
    do_xfer(2, 4'b1111, 8'h04, 4'b0000, 1, 0, 1);
    do_xfer(2, 4'b1011, 8'h08, 4'b1010, 1, 0, 1);
    do_xfer(1, 4'b0000, 8'h00, 4'b0000, 1, 0, 1);
    // R8 pokes during a transfer
    do_xfer(3, 4'b0101, 8'h09, 4'h0, 1, 1, 1);
    // R7 sticky across transfers without clear
    do_xfer(1, 4'b0001, 8'h00, 4'h0, 1, 0, 0);
    repeat (5) @(negedge clk);
    chk(irq_n == 0, "R7 irq held without clear", irq_n, 0);
    do_xfer(1, 4'b0001, 8'h00, 4'h0, 1, 0, 1);
    // random mix
    for (int k = 0; k < 14; k++) begin
      logic [7:0] c;
      logic [1:0] rt;
      int nb;
      rt = 2'($urandom_range(0, 3));
      nb = (rt == 2'd3) ? $urandom_range(1, 3) : $urandom_range(1, 6);
      c  = {2'b00, 1'($urandom), 1'b0, 2'($urandom), rt};
      do_xfer(nb, 4'($urandom), c, 4'($urandom), 1, 0, 1);
    end
    summary();
  end
endmodule